// File: doc/BRIEF.md
# Single-Cycle Asynchronous SRAM Access Controller

This block lets a synchronous core drive an external asynchronous SRAM with one access per core clock cycle. The core hands over requests on a valid/ready channel: a write flag, an address and, for writes, the data. Each accepted request becomes one access cycle on the SRAM pins, starting at the next rising core clock edge. Address and write data are registered and stay put for that whole cycle. The active-low write strobe or output-enable strobe is low only in the second half of the cycle.

The strobes are not made by gating the clock or by delay lines. A second clock at twice the core frequency, with its rising edges aligned to the core clock, clocks a pair of flops that produce the strobes directly. The strobes are therefore registered and can only change on clock edges. The falling strobe edge comes half a core period after the address changes, which gives setup margin. The rising edge coincides with the next core edge, which gives hold margin.

A write that directly follows a read would have the core's data drivers turn on while the SRAM is still driving the bus. In that case the controller inserts one dead cycle by holding back the write for one cycle. Going from a write to a read needs no dead cycle. Read data is captured on the core edge that closes the read cycle and is presented with a one-cycle valid pulse.

Back-pressure rules: a request transfers on a rising core edge where `req_valid` and `req_ready` are both high. Once the core raises `req_valid`, it holds the request unchanged until that transfer. `req_ready` drops only when the access cycle in progress is a read and the offered request is a write.

Top module: `sram_1cyc_ctrl`

## Requirements
- R1: While `rst_n` is low, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `rd_valid` is 0, and `req_ready` is 1 when `req_valid` is 0.
- R2: A request that transfers on a core edge drives its address on `sram_addr`, and for a write its data on `sram_dq_out`, from that edge until the next core edge, unchanged throughout.
- R3: During a write access cycle, `sram_we_n` is 1 in the first half of the cycle and 0 in the second half. It returns to 1 at the core edge that closes the cycle.
- R4: During a read access cycle, `sram_oe_n` is 1 in the first half and 0 in the second half. The two strobes are never low together.
- R5: `sram_dq_oe` is 1 exactly during write access cycles and 0 in all other cycles.
- R6: When the cycle in progress is a read and a write is offered, `req_ready` is 0 for that cycle. The next cycle is an idle cycle in which both strobes stay 1 and `sram_dq_oe` is 0, after which the write is accepted.
- R7: A read offered while a write cycle is in progress, or any request offered while a read or idle cycle is in progress (apart from the R6 case), is accepted at once (`req_ready` is 1).
- R8: For each read, `rd_valid` is 1 for exactly the one cycle after the read access cycle. In that cycle `rd_data` holds the SRAM data present at the end of the read cycle.
- R9: A core cycle with no transferred request leaves both strobes at 1 and `sram_dq_oe` at 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| clk2x | input | 1 | Double-rate clock, rising edges aligned with `clk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can transfer this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Captured read data |
| sram_addr | output | ADDR_W | SRAM address |
| sram_dq_out | output | DATA_W | Data driven toward the SRAM |
| sram_dq_oe | output | 1 | Enable for the core's data drivers |
| sram_dq_in | input | DATA_W | Data returned by the SRAM |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low SRAM output enable |

## Verification
The bench first runs a directed sequence that steps through every access-type transition: write to read, read to write, read to read, write to write, and an idle cycle between accesses. Only the read-to-write step may lose a cycle, and comparing the steps shows that the dead cycle appears there and nowhere else. A seeded random phase follows, with mixed valid gaps and a small address space, so reads often land on addresses written just before. Each strobe is sampled once per half cycle, which shows whether it falls at the mid-cycle edge rather than at the opening edge. The behavioural SRAM in the bench returns a marker value whenever its output enable is high, so a capture taken outside the enabled window shows up as wrong read data.

// File: rtl/sram_1cyc_pkg.sv
package sram_1cyc_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/sram_req_stage.sv
module sram_req_stage
  import sram_1cyc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output acc_kind_e         acc_kind,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata
);
  logic fire;

  // A write behind a read must wait one cycle for the bus to turn around.
  always_comb begin
    req_ready = !((acc_kind == ACC_READ) && req_valid && req_write);
    fire      = req_valid && req_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_kind  <= ACC_IDLE;
      acc_addr  <= '0;
      acc_wdata <= '0;
    end else if (fire) begin
      acc_kind  <= req_write ? ACC_WRITE : ACC_READ;
      acc_addr  <= req_addr;
      if (req_write) acc_wdata <= req_wdata;
    end else begin
      acc_kind  <= ACC_IDLE;
    end
  end

  // R6: a write cycle never directly follows a read cycle
  a_r6_no_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_READ) |=> (acc_kind != ACC_WRITE));

  // R2: the address only moves when a new request transferred
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fire) |-> $stable(acc_addr));
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen (
  input  logic clk,
  input  logic clk2x,
  input  logic rst_n,
  input  logic acc_wr,
  input  logic acc_rd,
  output logic sram_we_n,
  output logic sram_oe_n
);
  // Core-domain toggle; the double-rate domain sees it change only at the
  // mid-cycle edge, which marks the start of the second half-period.
  logic core_tog;
  logic tog_seen;
  logic mid_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_tog <= 1'b0;
    else        core_tog <= ~core_tog;
  end

  assign mid_edge = core_tog ^ tog_seen;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      tog_seen  <= 1'b0;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
    end else begin
      tog_seen  <= core_tog;
      sram_we_n <= ~(mid_edge & acc_wr);
      sram_oe_n <= ~(mid_edge & acc_rd);
    end
  end

  // R3: write strobe lasts a single half core period
  a_r3_we_half_period: assert property (@(posedge clk2x) disable iff (!rst_n)
    !sram_we_n |=> sram_we_n);

  // R3: write strobe only low inside a write access
  a_r3_we_in_write: assert property (@(posedge clk2x) disable iff (!rst_n)
    !sram_we_n |-> acc_wr);

  // R4: output-enable strobe lasts a single half core period
  a_r4_oe_half_period: assert property (@(posedge clk2x) disable iff (!rst_n)
    !sram_oe_n |=> sram_oe_n);

  // R4: the two strobes never overlap
  a_r4_strobes_exclusive: assert property (@(posedge clk2x) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_rd;
      if (acc_rd) rd_data <= sram_dq_in;
    end
  end

  // R8: a valid pulse only ever follows a read cycle
  a_r8_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_rd));
endmodule

// File: rtl/sram_1cyc_ctrl.sv
module sram_1cyc_ctrl
  import sram_1cyc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_we_n,
  output logic              sram_oe_n
);
  acc_kind_e         acc_kind;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic              acc_wr;
  logic              acc_rd;

  sram_req_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .acc_kind  (acc_kind),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata)
  );

  assign acc_wr = (acc_kind == ACC_WRITE);
  assign acc_rd = (acc_kind == ACC_READ);

  sram_strobe_gen u_strobe (
    .clk       (clk),
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_rd     (acc_rd),
    .sram_dq_in (sram_dq_in),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  assign sram_addr   = acc_addr;
  assign sram_dq_out = acc_wdata;
  assign sram_dq_oe  = acc_wr;

  // R5: core drivers are off whenever the SRAM is asked to drive the bus
  a_r5_no_contention: assert property (@(posedge clk2x) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);
endmodule

// File: tb/sram_1cyc_ctrl_tb.sv
module sram_1cyc_ctrl_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NCYC = 3000;
  localparam logic [DW-1:0] JUNK = 16'hA5C3;

  logic clk = 1'b0, clk2x = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, sram_dq_oe, sram_we_n, sram_oe_n;
  logic [DW-1:0] rd_data, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk2x = ~clk2x;
  always @(posedge clk2x) clk <= ~clk;

  sram_1cyc_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .clk2x(clk2x), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  // Behavioural asynchronous SRAM with a little output hold time.
  logic [DW-1:0] mem [1<<AW];
  logic [DW-1:0] dq_drv = JUNK;
  assign sram_dq_in = dq_drv;
  always @(negedge sram_we_n) if (rst_n) mem[sram_addr] <= sram_dq_out;
  always @(negedge sram_oe_n) if (rst_n) dq_drv <= mem[sram_addr];
  always @(posedge sram_oe_n) begin #2; dq_drv <= JUNK; end

  logic [DW-1:0] shadow [1<<AW];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic logic exp_ready(input bit cur_rd, input bit v, input bit w);
    return !(cur_rd && v && w);
  endfunction

  // Directed opening: W,R,W(turnaround),R,R,W(turnaround),W,idle,R,W(turnaround)
  function automatic logic [2+AW+DW-1:0] directed(input int i);
    case (i)
      0: return {1'b1, 1'b1, 8'h11, 16'h1234};
      1: return {1'b1, 1'b0, 8'h11, 16'h0000};
      2: return {1'b1, 1'b1, 8'h22, 16'hBEEF};
      3: return {1'b1, 1'b0, 8'h22, 16'h0000};
      4: return {1'b1, 1'b0, 8'h11, 16'h0000};
      5: return {1'b1, 1'b1, 8'h33, 16'h0F0F};
      6: return {1'b1, 1'b1, 8'h44, 16'hC001};
      7: return {1'b0, 1'b0, 8'h00, 16'h0000};
      8: return {1'b1, 1'b0, 8'h44, 16'h0000};
      default: return {1'b1, 1'b1, 8'h33, 16'h7777};
    endcase
  endfunction

  initial begin : watchdog
    #(NCYC * 20 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit cur_wr, cur_rd, pend, acc, nxt_wr, nxt_rd, old_rd;
    logic [AW-1:0] cur_addr, nxt_addr;
    logic [DW-1:0] cur_data, nxt_data, cur_rdexp, nxt_rdexp, old_rdexp;
    int dir_i;
    void'($urandom(32'd1997));
    for (int i = 0; i < (1 << AW); i++) begin mem[i] = '0; shadow[i] = '0; end
    cur_wr = 0; cur_rd = 0; pend = 0; acc = 0; dir_i = 0;
    nxt_wr = 0; nxt_rd = 0; nxt_addr = '0; nxt_data = '0; nxt_rdexp = '0;
    cur_addr = '0; cur_data = '0; cur_rdexp = '0;
    #33;
    // R1: reset state
    chk("R1 we_n", sram_we_n, 1); chk("R1 oe_n", sram_oe_n, 1);
    chk("R1 dq_oe", sram_dq_oe, 0); chk("R1 rd_valid", rd_valid, 0);
    chk("R1 ready", req_ready, 1);
    #40 rst_n = 1'b1;

    for (int n = 0; n < NCYC; n++) begin
      @(posedge clk);
      old_rd = cur_rd; old_rdexp = cur_rdexp;
      if (acc) begin
        cur_wr = nxt_wr; cur_rd = nxt_rd; cur_addr = nxt_addr;
        cur_data = nxt_data; cur_rdexp = nxt_rdexp;
      end else begin
        cur_wr = 0; cur_rd = 0;
      end
      #2;
      if (!pend) begin
        logic [2+AW+DW-1:0] r;
        if (dir_i < 10) begin r = directed(dir_i); dir_i++; end
        else begin
          r[2+AW+DW-1] = ($urandom % 10) < 7;
          r[2+AW+DW-2] = $urandom % 2;
          r[AW+DW-1:DW] = AW'($urandom % 8);
          r[DW-1:0] = DW'($urandom);
        end
        req_valid = r[2+AW+DW-1]; req_write = r[2+AW+DW-2];
        req_addr = r[AW+DW-1:DW]; req_wdata = r[DW-1:0];
      end
      #4; // first half of the access cycle
      chk(cur_rd && req_valid && req_write ? "R6 ready" : "R7 ready",
          req_ready, exp_ready(cur_rd, req_valid, req_write));
      chk("R3 we_n first half", sram_we_n, 1);
      chk("R4 oe_n first half", sram_oe_n, 1);
      chk("R5 dq_oe", sram_dq_oe, cur_wr);
      if (cur_wr || cur_rd) chk("R2 addr", sram_addr, cur_addr);
      if (cur_wr) chk("R2 wdata", sram_dq_out, cur_data);
      chk("R8 rd_valid", rd_valid, old_rd);
      if (old_rd) chk("R8 rd_data", rd_data, old_rdexp);
      acc = req_valid && exp_ready(cur_rd, req_valid, req_write);
      if (acc) begin
        nxt_wr = req_write; nxt_rd = !req_write;
        nxt_addr = req_addr; nxt_data = req_wdata;
        nxt_rdexp = shadow[req_addr];
        if (req_write) shadow[req_addr] = req_wdata;
      end
      pend = req_valid && !acc;
      #10; // second half of the access cycle
      chk(cur_wr ? "R3 we_n second half" : "R9 we_n idle", sram_we_n, !cur_wr);
      chk(cur_rd ? "R4 oe_n second half" : "R9 oe_n idle", sram_oe_n, !cur_rd);
      chk("R5 dq_oe second half", sram_dq_oe, cur_wr);
      if (cur_wr || cur_rd) chk("R2 addr held", sram_addr, cur_addr);
      if (cur_wr) chk("R2 wdata held", sram_dq_out, cur_data);
      if (acc) begin
        // keep offered request stable until the edge, then drop it
        fork begin @(posedge clk); #1; if (!pend) req_valid = 1'b0; end join_none
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule